// File: doc/BRIEF.md
# Modem Line Status and Control Unit

This unit holds the modem-side state of a 16550-style serial port. Four incoming handshake lines are carrier detect, ring, data-set-ready and clear-to-send. Each line passes through a synchroniser. The unit keeps the current level of each line in the upper nibble of an 8-bit status word. The lower nibble holds sticky change flags. A host read of the status word returns its value and then clears the change flags. While any change flag is set and the interrupt unit enables the source, a pending line is raised.

The unit also holds a 5-bit control word. Four of its bits drive the outgoing handshake pins: terminal-ready, request-to-send and two general-purpose outputs. The fifth bit selects loopback. In loopback the outgoing pins are forced low and the control bits stand in for the incoming lines. This lets software test the status path without touching the cable.

Top module: `mdm_line_unit`

## Requirements
- R1: After reset the control word reads 0x08, the status word reads 0xB0, the interrupt is low, and of the outgoing pins only the second general-purpose output (aux2Out) is high.
- R2: Status word layout: bit 7 carrier level, bit 6 ring level, bit 5 data-set-ready level, bit 4 clear-to-send level, bit 3 carrier changed, bit 2 ring ended, bit 1 data-set-ready changed, bit 0 clear-to-send changed.
- R3: A change flag for carrier, data-set-ready or clear-to-send is set when the line changes in either direction. It stays set through further changes until a status read.
- R4: The ring flag (bit 2) is set only when the ring level goes from 1 to 0. A rise of the ring level leaves it clear.
- R5: A status read returns the word as it stands in the strobe cycle and clears all four change flags at the following edge. A level change that lands on that same edge sets its flag anyway.
- R6: Control word: bit 4 loopback, bit 3 aux2, bit 2 aux1, bit 1 request-to-send, bit 0 terminal-ready. Bits 7:5 of a write are dropped and read as 0. Outside loopback each pin follows its bit one edge after the write.
- R7: In loopback the levels come from the control word: aux2 to carrier, aux1 to ring, terminal-ready to data-set-ready, request-to-send to clear-to-send. Changes on the external input lines have no effect on the status word.
- R8: While loopback is set, all four outgoing pins are low whatever the other control bits hold.
- R9: statIrq is high exactly when statusEn is high and at least one change flag is set. It drops after the read that clears the flags.
- R10: An external line change is first visible in the status word after the third rising edge following it: two synchroniser stages, then the level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Write strobe for the control word |
| statRdEn | input | 1 | Read strobe for the status word (clears change flags) |
| wrData | input | 8 | Host write data |
| statusEn | input | 1 | Modem-status interrupt enable from the interrupt unit |
| ctsIn | input | 1 | Clear-to-send line, active high |
| dsrIn | input | 1 | Data-set-ready line, active high |
| riIn | input | 1 | Ring line, active high |
| dcdIn | input | 1 | Carrier line, active high |
| ctlRd | output | 8 | Current control word |
| statRd | output | 8 | Current status word |
| dtrOut | output | 1 | Terminal-ready pin |
| rtsOut | output | 1 | Request-to-send pin |
| aux1Out | output | 1 | General-purpose output 1 |
| aux2Out | output | 1 | General-purpose output 2 |
| statIrq | output | 1 | Modem-status interrupt pending |

## Verification
A stale level register shows up at once as a wrong upper nibble on statRd. A bad edge comparison shows up as a missing or extra flag in the lower nibble, within three edges of a line change. A wrong clear or set priority is caught by a read whose strobe shares an edge with a line change. The next word then shows a lost or stale flag, and statIrq follows it in the same cycle. Loopback mistakes show as a wrong bit position within two edges of a control write, or as a pin left high one edge after the write.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINES  = 4;
  localparam int CTL_W  = 5;
  localparam int DATA_W = 8;
  // line index order: clear-to-send, data-set-ready, ring, carrier
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_AUX1 = 2;
  localparam int CB_AUX2 = 3;
  localparam int CB_LOOP = 4;
  localparam logic [LINES-1:0] LINE_RST = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_RST  = 5'b01000;

  typedef struct packed {
    logic             ctlWr;
    logic [CTL_W-1:0] ctlVal;
    logic             statClr;
  } hostOps_t;
endpackage

// File: rtl/mdm_host_ctrl.sv
module mdm_host_ctrl
  import mdm_pkg::*;
(
  input  logic              ctlWrEn,
  input  logic              statRdEn,
  input  logic [DATA_W-1:0] wrData,
  output hostOps_t          ops
);
  always_comb begin
    ops.ctlWr   = ctlWrEn;
    ops.ctlVal  = wrData[CTL_W-1:0];
    ops.statClr = statRdEn;
  end
endmodule

// File: rtl/mdm_datapath.sv
module mdm_datapath
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  hostOps_t         ops,
  input  logic [LINES-1:0] lineIn,
  input  logic             statusEn,
  output logic [CTL_W-1:0] ctlQ,
  output logic [7:0]       statOut,
  output logic [LINES-1:0] pinsOut,
  output logic             irqOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] lineQ, deltaQ, effLine, chg;
  logic             loopOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= LINE_RST;
    end else begin
      syncQ[0] <= lineIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctlQ <= CTL_RST;
    else if (ops.ctlWr) ctlQ <= ops.ctlVal;
  end

  assign loopOn = ctlQ[CB_LOOP];

  always_comb begin
    if (loopOn) begin
      effLine[IDX_CTS] = ctlQ[CB_RTS];
      effLine[IDX_DSR] = ctlQ[CB_DTR];
      effLine[IDX_RI]  = ctlQ[CB_AUX1];
      effLine[IDX_DCD] = ctlQ[CB_AUX2];
    end else begin
      effLine = syncQ[LAST];
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == IDX_RI) begin : g_trail
      assign chg[i] = lineQ[i] & ~effLine[i];
    end else begin : g_any
      assign chg[i] = lineQ[i] ^ effLine[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ  <= LINE_RST;
      deltaQ <= '0;
    end else begin
      lineQ  <= effLine;
      deltaQ <= (ops.statClr ? '0 : deltaQ) | chg;
    end
  end

  assign statOut = {lineQ, deltaQ};
  assign pinsOut = loopOn ? '0 : ctlQ[LINES-1:0];
  assign irqOut  = statusEn & (|deltaQ);

  // R3
  cts_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineQ[IDX_CTS] != $past(lineQ[IDX_CTS])) |-> deltaQ[IDX_CTS]);
  // R4
  ri_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(deltaQ[IDX_RI]) && deltaQ[IDX_RI]) |-> ($past(lineQ[IDX_RI]) && !lineQ[IDX_RI]));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ops.statClr) && $stable(lineQ)) |-> (deltaQ == '0));
endmodule

// File: rtl/mdm_line_unit.sv
module mdm_line_unit
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic       statRdEn,
  input  logic [7:0] wrData,
  input  logic       statusEn,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       riIn,
  input  logic       dcdIn,
  output logic [7:0] ctlRd,
  output logic [7:0] statRd,
  output logic       dtrOut,
  output logic       rtsOut,
  output logic       aux1Out,
  output logic       aux2Out,
  output logic       statIrq
);
  hostOps_t         ops;
  logic [CTL_W-1:0] ctlQ;
  logic [LINES-1:0] pins;
  logic [LINES-1:0] lineIn;

  assign lineIn = {dcdIn, riIn, dsrIn, ctsIn};

  mdm_host_ctrl u_ctrl (
    .ctlWrEn (ctlWrEn),
    .statRdEn(statRdEn),
    .wrData  (wrData),
    .ops     (ops)
  );

  mdm_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ops     (ops),
    .lineIn  (lineIn),
    .statusEn(statusEn),
    .ctlQ    (ctlQ),
    .statOut (statRd),
    .pinsOut (pins),
    .irqOut  (statIrq)
  );

  assign ctlRd   = {{(DATA_W-CTL_W){1'b0}}, ctlQ};
  assign dtrOut  = pins[CB_DTR];
  assign rtsOut  = pins[CB_RTS];
  assign aux1Out = pins[CB_AUX1];
  assign aux2Out = pins[CB_AUX2];

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statRdEn) && $stable(statRd[7:4])) |-> !statIrq);
  // R8
  loop_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRd[CB_LOOP] |-> !(dtrOut | rtsOut | aux1Out | aux2Out));
endmodule

// File: tb/mdm_line_unit_bench.sv
module mdm_line_unit_bench;
  logic       clk = 0;
  logic       rstN = 0;
  logic       ctlWrEn = 0, statRdEn = 0, statusEn = 0;
  logic [7:0] wrData = 0;
  logic       ctsIn = 1, dsrIn = 1, riIn = 0, dcdIn = 1;
  logic [7:0] ctlRd, statRd;
  logic       dtrOut, rtsOut, aux1Out, aux2Out, statIrq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expV[$];
  string      expR[$];

  always #2 clk = ~clk;

  mdm_line_unit u_mdm_line_unit (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doRead(input logic [7:0] v, input string req);
    expV.push_back(v);
    expR.push_back(req);
    statRdEn = 1;
    @(negedge clk);
    statRdEn = 0;
  endtask

  task automatic doWrite(input logic [7:0] v);
    wrData = v;
    ctlWrEn = 1;
    @(negedge clk);
    ctlWrEn = 0;
  endtask

  task automatic peek(input logic [7:0] v, input string req);
    #1 chk(statRd == v, req, statRd, v);
  endtask

  task automatic pins(input logic [3:0] v, input string req);
    #1 chk({aux2Out, aux1Out, rtsOut, dtrOut} == v, req,
           {aux2Out, aux1Out, rtsOut, dtrOut}, v);
  endtask

  // monitor: pops expectation for each read strobe
  always @(negedge clk) begin
    #1;
    if (statRdEn) begin
      if (expV.size() == 0) chk(0, "scoreboard-empty", statRd, 0);
      else begin
        logic [7:0] e;
        string r;
        e = expV.pop_front();
        r = expR.pop_front();
        chk(statRd == e, r, statRd, e);
      end
    end
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    #1 chk(ctlRd == 8'h08, "R1 ctl", ctlRd, 8'h08);
    chk(statIrq == 0, "R1 irq", statIrq, 0);
    pins(4'b1000, "R1 pins");
    @(negedge clk);
    doRead(8'hB0, "R1 R2 status");
    statusEn = 1;
    // R10 latency and R3 flag
    ctsIn = 0;
    cyc(2); peek(8'hB0, "R10 not yet");
    @(negedge clk); peek(8'hA1, "R10 visible R2");
    chk(statIrq == 1, "R9 irq set", statIrq, 1);
    dsrIn = 0;
    cyc(4);
    doRead(8'h83, "R3 accumulate");
    peek(8'h80, "R5 cleared");
    chk(statIrq == 0, "R9 irq drop", statIrq, 0);
    ctsIn = 1;
    cyc(4);
    doRead(8'h91, "R3 rising");
    // R4 ring
    riIn = 1;
    cyc(4); peek(8'hD0, "R4 rise no flag");
    chk(statIrq == 0, "R4 irq", statIrq, 0);
    riIn = 0;
    cyc(4);
    doRead(8'h94, "R4 trailing");
    // R9 enable gating
    statusEn = 0;
    dcdIn = 0;
    cyc(4); peek(8'h18, "R3 dcd");
    chk(statIrq == 0, "R9 masked", statIrq, 0);
    statusEn = 1;
    #1 chk(statIrq == 1, "R9 enabled", statIrq, 1);
    @(negedge clk);
    doRead(8'h18, "R5 read");
    // R5 change on the clearing edge
    dcdIn = 1;
    cyc(2);
    doRead(8'h10, "R5 concurrent read");
    peek(8'h98, "R5 flag kept");
    @(negedge clk);
    doRead(8'h98, "R5 reread");
    // R6 control word
    doWrite(8'h07);
    #1 chk(ctlRd == 8'h07, "R6 ctl", ctlRd, 8'h07);
    pins(4'b0111, "R6 pins");
    @(negedge clk);
    doWrite(8'hE3);
    #1 chk(ctlRd == 8'h03, "R6 upper dropped", ctlRd, 8'h03);
    pins(4'b0011, "R6 pins2");
    @(negedge clk);
    peek(8'h90, "R6 status untouched");
    // R7 R8 loopback
    dsrIn = 0;
    cyc(4);
    doWrite(8'h1F);
    pins(4'b0000, "R8 loop pins");
    @(negedge clk);
    cyc(2);
    doRead(8'hF2, "R7 loop all on");
    ctsIn = 0; dcdIn = 0; riIn = 1;
    cyc(5); peek(8'hF0, "R7 external ignored");
    doWrite(8'h1A);
    pins(4'b0000, "R8 loop pins2");
    @(negedge clk);
    cyc(2);
    doRead(8'h96, "R7 map aux2 rts");
    doWrite(8'h14);
    cyc(3);
    doRead(8'h49, "R7 map aux1");
    riIn = 0;
    cyc(4);
    doWrite(8'h00);
    cyc(3);
    doRead(8'h04, "R7 exit loop");
    doWrite(8'h0F);
    pins(4'b1111, "R6 pins all");
    @(negedge clk);
    cyc(2);
    chk(expV.size() == 0, "scoreboard drained", expV.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule